// File: doc/BRIEF.md
# Dual-Clock Presettable Up/Down Counter

This block is one four-bit counting stage. It has two count lines: one moves the value up and the other moves it down. The `DECADE` parameter picks the range. With `DECADE` set to 1 the stage counts 0 to 9, and with `DECADE` set to 0 it counts 0 to 15. A clear input and an active-low parallel load act on the outputs at once, ahead of any counting.

Everything runs from one fast system clock. Each count line passes through a two-flop synchroniser, and a rising edge on that line moves the count by one step. The carry and borrow outputs are active-low strobes. They have the shape of the count clock, so a chain of stages needs no glue logic. Each stage's carry drives the up line of the next stage, and each stage's borrow drives its down line.

Top module: `tally_stage`

## Requirements
- R1: While `clear` is high, `count` reads 0 in the same cycle. This holds even when `loadN` is low or a count edge is pending. A count edge detected in a cycle where `clear` is high is lost.
- R2: While `loadN` is low and `clear` is low, `count` equals `loadVal` bit for bit in the same cycle, and counting is suspended. The loaded value stays after `loadN` returns high.
- R3: A rising edge on `upIn` while `dnIn` is high adds one to the count. The new value appears at the third rising system clock edge after the change on `upIn`: two synchroniser flops, then the count register.
- R4: A rising edge on `dnIn` while `upIn` is high subtracts one from the count, with the same latency as R3.
- R5: A rising edge on one count line is ignored while the other count line is low.
- R6: If both count lines rise in the same synchronised cycle, the count does not change.
- R7: The count wraps in both directions. In decade mode, up from 9 gives 0 and down from 0 gives 9. In binary mode, up from 15 gives 0 and down from 0 gives 15.
- R8: In decade mode, an up step from any loaded value above 9 gives 0. In binary mode the same values simply increment.
- R9: `carryN` is low exactly when `count` holds the maximum (9 or 15) and the synchronised `upIn` is low. At all other times it is high.
- R10: `borrowN` is low exactly when `count` is 0 and the synchronised `dnIn` is low. At all other times it is high.
- R11: Stages chain with no extra logic. Tying one stage's `carryN` to the next stage's `upIn`, and its `borrowN` to the next stage's `dnIn`, counts correctly across decades in both directions.
- R12: While `rstN` is low, `count` is 0 and both strobes are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low system reset |
| clear | input | 1 | Active-high clear, overrides everything else |
| loadN | input | 1 | Active-low parallel load |
| loadVal | input | DIGIT_W | Parallel load value |
| upIn | input | 1 | Up-count clock line, idles high |
| dnIn | input | 1 | Down-count clock line, idles high |
| count | output | DIGIT_W | Current count |
| carryN | output | 1 | Active-low carry strobe |
| borrowN | output | 1 | Active-low borrow strobe |

## Verification
The risky case is a clear or a load that arrives in the same system cycle as a detected count edge. The bench raises `upIn` and waits two system clock edges for the synchroniser. It then asserts `clear` together with a low `loadN` in exactly the cycle where the increment is pending. The count must read 0 at once, then the load value once `clear` drops. It must stay at the load value afterwards, which shows the pending step was lost rather than applied late. A second coincidence, both count lines rising together, is also provoked, and the count must not change.

// File: rtl/tally_pkg.sv
package tally_pkg;
  typedef struct packed {
    logic clr;
    logic ld;
    logic incr;
    logic decr;
    logic upLow;
    logic dnLow;
  } strobe_t;
endpackage

// File: rtl/tally_sync.sv
module tally_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic lvl,
  output logic rise
);
  logic [STAGES:0] pipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pipe <= '1;
    else       pipe <= {pipe[STAGES-1:0], din};
  end

  assign lvl  = pipe[STAGES-1];
  assign rise = pipe[STAGES-1] & ~pipe[STAGES];
endmodule

// File: rtl/tally_ctrl.sv
module tally_ctrl
  import tally_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    clear,
  input  logic    loadN,
  input  logic    upIn,
  input  logic    dnIn,
  output strobe_t st
);
  localparam int LINES = 2;

  logic [LINES-1:0] lineIn, lineLvl, lineRise;
  assign lineIn = {dnIn, upIn};

  for (genvar i = 0; i < LINES; i++) begin : g_line
    tally_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rstN(rstN),
      .din (lineIn[i]),
      .lvl (lineLvl[i]),
      .rise(lineRise[i])
    );
  end

  always_comb begin
    st.clr   = clear;
    st.ld    = ~loadN;
    st.incr  = lineRise[0] & lineLvl[1] & ~lineRise[1];
    st.decr  = lineRise[1] & lineLvl[0] & ~lineRise[0];
    st.upLow = ~lineLvl[0];
    st.dnLow = ~lineLvl[1];
  end
endmodule

// File: rtl/tally_dp.sv
module tally_dp
  import tally_pkg::*;
#(
  parameter int DIGIT_W = 4,
  parameter bit DECADE  = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            st,
  input  logic [DIGIT_W-1:0] loadVal,
  output logic [DIGIT_W-1:0] count,
  output logic               carryN,
  output logic               borrowN
);
  localparam logic [DIGIT_W-1:0] CNT_MAX =
    DECADE ? DIGIT_W'(9) : {DIGIT_W{1'b1}};

  logic [DIGIT_W-1:0] cntQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        cntQ <= '0;
    else if (st.clr)  cntQ <= '0;
    else if (st.ld)   cntQ <= loadVal;
    else if (st.incr) cntQ <= (cntQ >= CNT_MAX) ? '0 : cntQ + 1'b1;
    else if (st.decr) cntQ <= (cntQ == '0) ? CNT_MAX : cntQ - 1'b1;
  end

  always_comb begin
    if (st.clr)     count = '0;
    else if (st.ld) count = loadVal;
    else            count = cntQ;
  end

  assign carryN  = ~((count == CNT_MAX) & st.upLow);
  assign borrowN = ~((count == '0) & st.dnLow);
endmodule

// File: rtl/tally_stage.sv
module tally_stage
  import tally_pkg::*;
#(
  parameter int DIGIT_W     = 4,
  parameter bit DECADE      = 1'b1,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               clear,
  input  logic               loadN,
  input  logic [DIGIT_W-1:0] loadVal,
  input  logic               upIn,
  input  logic               dnIn,
  output logic [DIGIT_W-1:0] count,
  output logic               carryN,
  output logic               borrowN
);
  strobe_t st;

  tally_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .clear(clear),
    .loadN(loadN),
    .upIn (upIn),
    .dnIn (dnIn),
    .st   (st)
  );

  tally_dp #(.DIGIT_W(DIGIT_W), .DECADE(DECADE)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .st     (st),
    .loadVal(loadVal),
    .count  (count),
    .carryN (carryN),
    .borrowN(borrowN)
  );
endmodule

// File: rtl/tally_chk.sv
module tally_chk #(
  parameter int DIGIT_W = 4,
  parameter bit DECADE  = 1'b1
) (
  input logic               clk,
  input logic               rstN,
  input logic               clear,
  input logic               loadN,
  input logic [DIGIT_W-1:0] loadVal,
  input logic [DIGIT_W-1:0] count,
  input logic               carryN,
  input logic               borrowN
);
  localparam logic [DIGIT_W-1:0] TOP = DECADE ? DIGIT_W'(9) : {DIGIT_W{1'b1}};

  function automatic logic [DIGIT_W-1:0] nextUp(input logic [DIGIT_W-1:0] v);
    return (v >= TOP) ? '0 : v + 1'b1;
  endfunction

  function automatic logic [DIGIT_W-1:0] nextDn(input logic [DIGIT_W-1:0] v);
    return (v == '0) ? TOP : v - 1'b1;
  endfunction

  p_clear_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    clear |-> count == '0);

  p_load_follow_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!clear && !loadN) |-> count == loadVal);

  // R7: between clears and loads the count only moves by one wrapped step
  p_single_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!clear && loadN && $past(!clear && loadN) && count != $past(count))
      |-> (count == nextUp($past(count)) || count == nextDn($past(count))));

  p_carry_at_top_r9: assert property (@(posedge clk) disable iff (!rstN)
    !carryN |-> count == TOP);

  p_borrow_at_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    !borrowN |-> count == '0);
endmodule

bind tally_stage tally_chk #(.DIGIT_W(DIGIT_W), .DECADE(DECADE)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .clear  (clear),
  .loadN  (loadN),
  .loadVal(loadVal),
  .count  (count),
  .carryN (carryN),
  .borrowN(borrowN)
);

// File: tb/tally_stage_tb.sv
`timescale 1ns/100ps
module tally_stage_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic clear = 1'b0;
  logic loadN = 1'b1;
  logic [3:0] loadVal = '0;
  logic upIn = 1'b1;
  logic dnIn = 1'b1;
  logic [3:0] count, countB, countNx, unusedNx;
  logic carryN, borrowN, cyB, bwB, cyNx, bwNx;

  always #2.5 clk = ~clk;

  tally_stage #(.DIGIT_W(4), .DECADE(1'b1)) u_dut (
    .clk(clk), .rstN(rstN), .clear(clear), .loadN(loadN), .loadVal(loadVal),
    .upIn(upIn), .dnIn(dnIn), .count(count), .carryN(carryN), .borrowN(borrowN));

  tally_stage #(.DIGIT_W(4), .DECADE(1'b0)) u_bin (
    .clk(clk), .rstN(rstN), .clear(clear), .loadN(loadN), .loadVal(loadVal),
    .upIn(upIn), .dnIn(dnIn), .count(countB), .carryN(cyB), .borrowN(bwB));

  assign unusedNx = '0;
  tally_stage #(.DIGIT_W(4), .DECADE(1'b1)) u_next (
    .clk(clk), .rstN(rstN), .clear(clear), .loadN(1'b1), .loadVal(unusedNx),
    .upIn(carryN), .dnIn(borrowN), .count(countNx), .carryN(cyNx), .borrowN(bwNx));

  typedef struct {
    string tag;
    int    sel;
    int    expv;
  } item_t;

  item_t q[$];
  event  pushed;
  int    checks = 0;
  int    failures = 0;
  int    mdl = 0;
  int    mdlB = 0;
  bit    finished = 1'b0;

  // scoreboard monitor: pops expected items and compares with the ports
  initial begin
    forever begin
      @(pushed);
      while (q.size() > 0) begin
        item_t it;
        int act;
        it = q.pop_front();
        case (it.sel)
          0: act = int'(count);
          1: act = int'(carryN);
          2: act = int'(borrowN);
          3: act = int'(countB);
          default: act = int'(countNx);
        endcase
        checks++;
        if (act != it.expv) begin
          failures++;
          $display("FAIL %s actual=%0d expected=%0d", it.tag, act, it.expv);
        end
      end
    end
  end

  task automatic expect_(input string tag, input int sel, input int expv);
    item_t it;
    it.tag = tag; it.sel = sel; it.expv = expv;
    q.push_back(it);
    -> pushed;
    #0.1;
  endtask

  function automatic int stepUp(input int v, input int top);
    return (v >= top) ? 0 : v + 1;
  endfunction

  function automatic int stepDn(input int v, input int top);
    return (v == 0) ? top : v - 1;
  endfunction

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseUp();
    upIn = 1'b0; waitN(4);
    upIn = 1'b1; waitN(8);
    mdl = stepUp(mdl, 9); mdlB = stepUp(mdlB, 15);
  endtask

  task automatic pulseDn();
    dnIn = 1'b0; waitN(4);
    dnIn = 1'b1; waitN(8);
    mdl = stepDn(mdl, 9); mdlB = stepDn(mdlB, 15);
  endtask

  task automatic loadNow(input int v);
    loadN = 1'b0; loadVal = 4'(v); #0.5;
    expect_("R2 load visible at once", 0, v);
    waitN(1); loadN = 1'b1; waitN(2);
    mdl = v; mdlB = v;
  endtask

  task automatic both(input string tag);
    expect_(tag, 0, mdl);
    expect_(tag, 3, mdlB);
  endtask

  initial begin
    #100000;
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    waitN(3);
    expect_("R12 reset count", 0, 0);
    expect_("R12 reset carry", 1, 1);
    expect_("R12 reset borrow", 2, 1);
    rstN = 1'b1; waitN(2);

    loadNow(7);
    both("R2 load 7 held");
    pulseUp();
    both("R3 up step");
    pulseUp();
    both("R3 up to max");

    upIn = 1'b0; waitN(3);
    expect_("R9 carry low at max with up low", 1, 0);
    expect_("R10 borrow high when not zero", 2, 1);
    upIn = 1'b1; waitN(8);
    mdl = stepUp(mdl, 9); mdlB = stepUp(mdlB, 15);
    both("R7 decade wrap up");
    expect_("R9 carry high after wrap", 1, 1);

    loadNow(0);
    dnIn = 1'b0; waitN(3);
    expect_("R10 borrow low at zero with down low", 2, 0);
    expect_("R9 carry high when not max", 1, 1);
    dnIn = 1'b1; waitN(8);
    mdl = stepDn(mdl, 9); mdlB = stepDn(mdlB, 15);
    both("R7 R4 wrap down");

    loadNow(12);
    pulseUp();
    expect_("R8 decade above nine goes to zero", 0, 0);
    expect_("R8 binary increments", 3, 13);

    loadNow(15);
    pulseUp();
    both("R7 binary wrap up");
    pulseDn();
    both("R7 binary wrap down");

    loadNow(5);
    dnIn = 1'b0; waitN(4);
    upIn = 1'b0; waitN(4);
    upIn = 1'b1; waitN(8);
    both("R5 up ignored while down low");
    dnIn = 1'b1; waitN(8);
    mdl = stepDn(mdl, 9); mdlB = stepDn(mdlB, 15);
    both("R4 down edge with up high");

    upIn = 1'b0; dnIn = 1'b0; waitN(4);
    upIn = 1'b1; dnIn = 1'b1; waitN(8);
    both("R6 simultaneous edges cancel");

    loadNow(4);
    upIn = 1'b0; waitN(4);
    upIn = 1'b1; waitN(2);
    clear = 1'b1; loadN = 1'b0; loadVal = 4'd6; #0.5;
    expect_("R1 clear over load and pending edge", 0, 0);
    waitN(1);
    clear = 1'b0; #0.5;
    expect_("R2 load after clear", 0, 6);
    waitN(1); loadN = 1'b1; waitN(8);
    mdl = 6; mdlB = 6;
    both("R1 pending edge lost");

    clear = 1'b1; waitN(1); clear = 1'b0; waitN(2);
    mdl = 0; mdlB = 0;
    expect_("R1 clear stage two", 4, 0);
    for (int i = 0; i < 10; i++) pulseUp();
    expect_("R11 ones after ten", 0, 0);
    expect_("R11 tens after ten", 4, 1);
    pulseDn();
    expect_("R11 ones after borrow", 0, 9);
    expect_("R11 tens after borrow", 4, 0);

    waitN(2);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule